// File: doc/BRIEF.md
# Load/Store Request to AHB-Lite Master Bridge

This block sits between a processor's native load/store port and an AHB-Lite bus. The processor raises a request level with a direction bit, an address, store data and a transfer size. When the bridge is free it takes the request into a holding register. It then runs one single bus transfer with a pipelined address phase and data phase. At the end it gives the processor a one-cycle completion pulse, an error flag and, for loads, the returned data.

The bridge never makes bursts. Every transfer is marked non-sequential and single, and the transfer type is idle at all other times. Slave wait states stretch whichever phase is active. An error response from the slave goes back to the processor as an error flag on the completion pulse. Address decoding, slave selection, return-data multiplexing and arbitration belong to the surrounding interconnect.

Top module: `lsb_ahb_master`

## Requirements
- R1: A request with `cpu_we_i`=0 (load) starts a read (`hwrite_o`=0), and one with `cpu_we_i`=1 (store) starts a write (`hwrite_o`=1). `haddr_o` and `hsize_o` carry the captured address and size.
- R2: `htrans_o` is NONSEQ (2'b10) during the address phase and IDLE (2'b00) in every other cycle. BUSY (2'b01) and SEQ (2'b11) never appear.
- R3: `hburst_o` is SINGLE (3'b000) in every cycle.
- R4: While `hready_i` is low during the address phase, the address phase is extended. `htrans_o`, `haddr_o`, `hwrite_o` and `hsize_o` hold their values.
- R5: The data phase begins in the cycle after the address phase completes with `hready_i` high. During it `hwdata_o` carries the captured store data and holds while `hready_i` is low. No completion is signalled while `hready_i` is low.
- R6: `cpu_done_o` is high for exactly one cycle, in the cycle after the data-phase cycle in which `hready_i` is high. `cpu_err_o` is high with it exactly when `hresp_i` was 1 (ERROR) in that cycle, and is low otherwise.
- R7: When `hresp_i`=1 is seen with `hready_i` low in the data phase (the first cycle of an error response), `htrans_o` is IDLE in the next cycle.
- R8: For a load that completes normally, `cpu_rdata_o` shows, in the same cycle as the completion pulse, the value of `hrdata_i` from the data-phase cycle in which `hready_i` was high.
- R9: A request is accepted only on a clock edge where `cpu_rdy_o` is high. `cpu_rdy_o` is low from acceptance through the completion-pulse cycle. Changes on the request inputs in that span do not affect the bus outputs of the transfer in progress.
- R10: While reset is applied and after it is released, `htrans_o` is IDLE, `cpu_done_o` is low and `cpu_rdy_o` is high until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_i | input | 1 | Processor request level |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | AW | Request address |
| cpu_wdata_i | input | DW | Store data |
| cpu_size_i | input | 3 | Transfer size code, passed to the bus |
| cpu_rdy_o | output | 1 | Bridge free to accept a request |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_err_o | output | 1 | Error flag, valid with completion |
| cpu_rdata_o | output | DW | Load data, valid with completion |
| haddr_o | output | AW | Bus address |
| htrans_o | output | 2 | Bus transfer type |
| hburst_o | output | 3 | Bus burst type |
| hwrite_o | output | 1 | Bus direction |
| hsize_o | output | 3 | Bus transfer size |
| hwdata_o | output | DW | Bus write data |
| hrdata_i | input | DW | Bus read data |
| hready_i | input | 1 | Slave ready |
| hresp_i | input | 1 | Slave response, 1 = ERROR |

## Verification
Directed cases cover zero-wait loads and stores, a long stall in the address phase, a long stall in the data phase, and the two-cycle error response. Together they separate the timing of each phase from the timing of completion. Random transfers mix direction, size, address and data with random stall lengths in both phases and random error responses. Only per-phase stall counts can reveal a phase that is skipped or held too long. In some transfers the request inputs keep changing with request still asserted, which shows whether the captured register is really held and whether back-to-back acceptance respects the completion pulse.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;
  localparam logic [2:0] BU_SINGLE = 3'b000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ADDR = 2'b01,
    ST_DATA = 2'b10
  } lsb_state_e;
endpackage

// File: rtl/lsb_rst_sync.sv
module lsb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/lsb_req_reg.sv
module lsb_req_reg #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          load_en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] size_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [SW-1:0] size_o
);
  logic          we_q,    we_d;
  logic [AW-1:0] addr_q,  addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [SW-1:0] size_q,  size_d;

  always_comb begin
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    size_d  = size_q;
    if (load_en_i) begin
      we_d    = we_i;
      addr_d  = addr_i;
      wdata_d = wdata_i;
      size_d  = size_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
    end else begin
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      size_q  <= size_d;
    end
  end

  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign size_o  = size_q;
endmodule

// File: rtl/lsb_xfer_fsm.sv
module lsb_xfer_fsm
  import lsb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       req_i,
  input  logic       done_i,
  input  logic       hready_i,
  input  logic       hresp_i,
  output logic       accept_o,
  output logic       rdy_o,
  output logic       data_end_o,
  output logic       in_data_o,
  output logic [1:0] htrans_o
);
  lsb_state_e st_q, st_d;

  assign rdy_o      = (st_q == ST_IDLE) && !done_i;
  assign accept_o   = rdy_o && req_i;
  assign in_data_o  = (st_q == ST_DATA);
  assign data_end_o = in_data_o && hready_i;
  assign htrans_o   = (st_q == ST_ADDR) ? TR_NONSEQ : TR_IDLE;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_ADDR;
      ST_ADDR: if (hready_i) st_d = ST_DATA;
      ST_DATA: if (hready_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    st_q inside {ST_IDLE, ST_ADDR, ST_DATA}); // R2
  AST_ERR_FIRST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (in_data_o && !hready_i && hresp_i) |=> (htrans_o == TR_IDLE)); // R7
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (htrans_o == TR_NONSEQ && hready_i) |=> in_data_o); // R5
endmodule

// File: rtl/lsb_resp_reg.sv
module lsb_resp_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          data_end_i,
  input  logic          hresp_i,
  input  logic [DW-1:0] hrdata_i,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o
);
  logic          done_q,  done_d;
  logic          err_q,   err_d;
  logic [DW-1:0] rdata_q, rdata_d;

  always_comb begin
    done_d  = data_end_i;
    err_d   = data_end_i && hresp_i;
    rdata_d = rdata_q;
    if (data_end_i) rdata_d = hrdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q  <= done_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_o |-> done_o); // R6
endmodule

// File: rtl/lsb_ahb_master.sv
module lsb_ahb_master
  import lsb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic [2:0]    cpu_size_i,
  output logic          cpu_rdy_o,
  output logic          cpu_done_o,
  output logic          cpu_err_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic [AW-1:0] haddr_o,
  output logic [1:0]    htrans_o,
  output logic [2:0]    hburst_o,
  output logic          hwrite_o,
  output logic [2:0]    hsize_o,
  output logic [DW-1:0] hwdata_o,
  input  logic [DW-1:0] hrdata_i,
  input  logic          hready_i,
  input  logic          hresp_i
);
  localparam int SW = 3;

  logic rst_n_s;
  logic accept, data_end, in_data, done_w;

  lsb_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .rst_n_o(rst_n_s)
  );

  lsb_req_reg #(.AW(AW), .DW(DW), .SW(SW)) u_req (
    .clk_i(clk_i), .rst_n_i(rst_n_s), .load_en_i(accept),
    .we_i(cpu_we_i), .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i), .size_i(cpu_size_i),
    .we_o(hwrite_o), .addr_o(haddr_o), .wdata_o(hwdata_o), .size_o(hsize_o)
  );

  lsb_xfer_fsm u_fsm (
    .clk_i(clk_i), .rst_n_i(rst_n_s), .req_i(cpu_req_i), .done_i(done_w),
    .hready_i(hready_i), .hresp_i(hresp_i), .accept_o(accept), .rdy_o(cpu_rdy_o),
    .data_end_o(data_end), .in_data_o(in_data), .htrans_o(htrans_o)
  );

  lsb_resp_reg #(.DW(DW)) u_resp (
    .clk_i(clk_i), .rst_n_i(rst_n_s), .data_end_i(data_end), .hresp_i(hresp_i),
    .hrdata_i(hrdata_i), .done_o(done_w), .err_o(cpu_err_o), .rdata_o(cpu_rdata_o)
  );

  assign cpu_done_o = done_w;
  assign hburst_o   = BU_SINGLE;

  AST_NO_BURST_TYPES: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (htrans_o != TR_BUSY) && (htrans_o != TR_SEQ)); // R2
  AST_ADDR_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (htrans_o == TR_NONSEQ && !hready_i) |=>
      (htrans_o == TR_NONSEQ) && $stable(haddr_o) && $stable(hwrite_o) && $stable(hsize_o)); // R4
  AST_WDATA_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (in_data && !hready_i) |=> $stable(hwdata_o)); // R5
  AST_DONE_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (in_data && !hready_i) |=> !cpu_done_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    cpu_done_o |=> !cpu_done_o); // R6
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    cpu_done_o |-> !cpu_rdy_o); // R9
endmodule

// File: tb/lsb_ahb_master_tb_top.sv
module lsb_ahb_master_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [2:0]    size;
  logic          rdy, done, err;
  logic [DW-1:0] rdata;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic [2:0]    hburst, hsize;
  logic          hwrite;
  logic [DW-1:0] hwdata, hrdata;
  logic          hready, hresp;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lsb_ahb_master #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .cpu_req_i(req), .cpu_we_i(we),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_size_i(size),
    .cpu_rdy_o(rdy), .cpu_done_o(done), .cpu_err_o(err), .cpu_rdata_o(rdata),
    .haddr_o(haddr), .htrans_o(htrans), .hburst_o(hburst), .hwrite_o(hwrite),
    .hsize_o(hsize), .hwdata_o(hwdata), .hrdata_i(hrdata), .hready_i(hready),
    .hresp_i(hresp)
  );

  function automatic logic [1:0] exp_trans(input bit addr_phase);
    return addr_phase ? 2'b10 : 2'b00;
  endfunction

  function automatic logic exp_err(input bit resp_err);
    return resp_err ? 1'b1 : 1'b0;
  endfunction

  task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // One complete transfer; junk keeps request asserted with changing fields.
  task automatic xfer(input bit t_we, input logic [AW-1:0] t_addr, input logic [DW-1:0] t_wd,
                      input logic [2:0] t_sz, input int aw, input int dw, input bit t_err,
                      input logic [DW-1:0] t_rd, input bit junk);
    while (!rdy) @(negedge clk);
    chk("R6 done low between", {63'b0, done}, 64'd0);
    req = 1; we = t_we; addr = t_addr; wdata = t_wd; size = t_sz;
    @(negedge clk);
    // address phase
    if (junk) begin req = 1; we = ~t_we; addr = ~t_addr; wdata = ~t_wd; size = ~t_sz; end
    else req = 0;
    chk("R2 nonseq", {62'b0, htrans}, {62'b0, exp_trans(1)});
    chk("R1 addr", {32'b0, haddr}, {32'b0, t_addr});
    chk("R1 write", {63'b0, hwrite}, {63'b0, t_we});
    chk("R1 size", {61'b0, hsize}, {61'b0, t_sz});
    chk("R3 single", {61'b0, hburst}, 64'd0);
    chk("R9 rdy low", {63'b0, rdy}, 64'd0);
    hready = (aw > 0) ? 1'b0 : 1'b1;
    for (int i = 0; i < aw; i++) begin
      @(negedge clk);
      if (junk) begin addr = addr + 1; wdata = wdata ^ 32'h55; end
      chk("R4 nonseq held", {62'b0, htrans}, 64'd2);
      chk("R4 addr held", {32'b0, haddr}, {32'b0, t_addr});
      hready = (i == aw - 1) ? 1'b1 : 1'b0;
    end
    @(negedge clk);
    // data phase
    chk("R2 idle in data", {62'b0, htrans}, {62'b0, exp_trans(0)});
    if (t_we) chk("R5 hwdata", {32'b0, hwdata}, {32'b0, t_wd});
    chk("R9 addr kept", {32'b0, haddr}, {32'b0, t_addr});
    for (int i = 0; i < dw; i++) begin
      hready = 0; hresp = 0; hrdata = $urandom;
      @(negedge clk);
      if (junk) addr = addr + 3;
      chk("R5 no done in wait", {63'b0, done}, 64'd0);
      if (t_we) chk("R5 hwdata held", {32'b0, hwdata}, {32'b0, t_wd});
      chk("R2 idle in wait", {62'b0, htrans}, 64'd0);
    end
    if (t_err) begin
      hready = 0; hresp = 1;
      @(negedge clk);
      chk("R7 idle after err1", {62'b0, htrans}, 64'd0);
      chk("R5 no done err1", {63'b0, done}, 64'd0);
    end
    hready = 1; hresp = t_err; hrdata = t_rd;
    @(negedge clk);
    hresp = 0; hrdata = $urandom;
    chk("R6 done", {63'b0, done}, 64'd1);
    chk("R6 err", {63'b0, err}, {63'b0, exp_err(t_err)});
    if (!t_we && !t_err) chk("R8 rdata", {32'b0, rdata}, {32'b0, t_rd});
    chk("R9 rdy low at done", {63'b0, rdy}, 64'd0);
    chk("R2 idle at done", {62'b0, htrans}, 64'd0);
    req = 0;
    @(negedge clk);
    chk("R6 pulse one cycle", {63'b0, done}, 64'd0);
    chk("R9 rdy back", {63'b0, rdy}, 64'd1);
  endtask

  initial begin
    req = 0; we = 0; addr = '0; wdata = '0; size = '0;
    hready = 1; hresp = 0; hrdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R10 idle in reset", {62'b0, htrans}, 64'd0);
    chk("R10 done low in reset", {63'b0, done}, 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 idle after reset", {62'b0, htrans}, 64'd0);
    chk("R10 done low", {63'b0, done}, 64'd0);
    chk("R10 rdy high", {63'b0, rdy}, 64'd1);
    chk("R3 single idle", {61'b0, hburst}, 64'd0);

    // directed corner cases
    xfer(0, 32'h1000_0000, 32'h0, 3'd2, 0, 0, 0, 32'hCAFE_F00D, 0);
    xfer(1, 32'h2000_0004, 32'hDEAD_BEEF, 3'd2, 0, 0, 0, 32'h0, 0);
    xfer(1, 32'h3000_0008, 32'h1234_5678, 3'd1, 5, 0, 0, 32'h0, 1);
    xfer(0, 32'h4000_000C, 32'h0, 3'd0, 0, 7, 0, 32'hA5A5_5A5A, 1);
    xfer(0, 32'h5000_0010, 32'h0, 3'd2, 1, 2, 1, 32'hFFFF_FFFF, 0);
    xfer(1, 32'h6000_0014, 32'h0BAD_0BAD, 3'd2, 0, 0, 1, 32'h0, 1);

    void'($urandom(32'd20240611));
    for (int k = 0; k < 60; k++) begin
      xfer($urandom_range(0, 1), $urandom, $urandom, 3'($urandom_range(0, 2)),
           $urandom_range(0, 3), $urandom_range(0, 4), ($urandom_range(0, 4) == 0),
           $urandom, $urandom_range(0, 1));
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end
endmodule